// File: doc/BRIEF.md
# Field Parity and Frame Output Generator

This block decides, once per television field, whether the field just starting is odd or even. It measures where the rising edge of the vertical sync lands inside the current horizontal line. A free-running position counter restarts on every horizontal sync edge, and the vertical sync edge samples it. The sampled position is then compared with half of a programmable line length. An edge in the later half of the line means an odd field. An edge in the earlier half means an even field.

A guard window of `GUARD` clocks sits around the line start and around the mid-point. A sample that falls inside either window is not trusted. The block simply alternates the field instead, so the odd/even sequence stays regular even when the vertical edge sits exactly on a line boundary or on the half-line point.

The block drives two outputs:
- `frame_out`, which feeds a de-interlacing deflection stage. It can be forced low outright, or forced low automatically while live video is on screen.
- `field_odd`, which goes to the downstream vertical timing. It can be inverted by a polarity control that never touches `frame_out`.

Top module: `field_frame_gen`

## Requirements
- R1: With no gating active, a vertical sync edge whose sampled line position is below half of `line_len` and outside the guard windows gives an even field: `field_odd`=0 and `frame_out`=0.
- R2: With no gating active, a vertical sync edge whose sampled position is at or above half of `line_len` and outside the guard windows gives an odd field: `field_odd`=1 and `frame_out`=1.
- R3: A sampled position within `GUARD` clocks of the line start (below `GUARD`, or at or above `line_len`-`GUARD`), or within `GUARD` clocks of the mid-point, makes the new field the complement of the previous one.
- R4: While `dis_frame`=1, `frame_out` is 0, and `field_odd` still follows the measured field.
- R5: While `auto_frame`=1, `frame_out` is 0 when `video_on`=1 and follows the field when `video_on`=0.
- R6: `field_pol`=1 inverts `field_odd` and leaves `frame_out` unchanged.
- R7: The half-line threshold follows the `line_len` input, so a new line length moves the odd/even boundary.
- R8: The field value changes only in response to a vertical sync edge, and holds across whole lines without one.
- R9: Synchronous reset sets `field_odd`=0 and `frame_out`=0, and sets the previous field to even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active on rising edge |
| vsync_in | input | 1 | Vertical sync, asynchronous, active on rising edge |
| line_len | input | LEN_W | Line length in clocks |
| video_on | input | 1 | High while video is displayed |
| dis_frame | input | 1 | Force `frame_out` low |
| auto_frame | input | 1 | Force `frame_out` low while video is displayed |
| field_pol | input | 1 | Invert `field_odd` for the vertical timing |
| frame_out | output | 1 | De-interlace frame signal |
| field_odd | output | 1 | Field flag for vertical timing, 1 = odd |

## Verification
The bench places the vertical edge at several chosen offsets from the horizontal edge. It uses clear first-half and second-half positions, positions inside the mid-point guard, and positions inside the line-start guard on both sides of the wrap. A design without the guard, or with a guard on the wrong side, would measure these marginal edges and fail to alternate. Each gating control is toggled while an odd field is held. A design that let polarity reach `frame_out`, or let `dis_frame` clear the field flag, would then show the wrong value on one of the two outputs. A second line length shows whether the threshold tracks `line_len` or a fixed constant.

// File: rtl/field_pkg.sv
package field_pkg;
  typedef enum logic {
    FLD_EVEN = 1'b0,
    FLD_ODD  = 1'b1
  } field_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/hpos_counter.sv
module hpos_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] POS_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || restart)     pos <= '0;
    else if (pos != POS_MAX) pos <= pos + 1'b1;
  end
endmodule

// File: rtl/parity_classifier.sv
module parity_classifier
  import field_pkg::*;
#(
  parameter int W     = 12,
  parameter int GUARD = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] line_len,
  output field_e       field
);
  localparam int XW = W + 1;
  localparam logic [XW-1:0] G = XW'(GUARD);

  logic [XW-1:0] pos_x, len_x, half_x;
  logic          near_start, near_mid, late_half;

  always_comb begin
    pos_x      = {1'b0, pos};
    len_x      = {1'b0, line_len};
    half_x     = len_x >> 1;
    near_start = (pos_x < G) || (pos_x + G >= len_x);
    near_mid   = (pos_x + G > half_x) && (pos_x < half_x + G);
    late_half  = (pos_x >= half_x);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field <= FLD_EVEN;
    end else if (sample) begin
      if (near_start || near_mid) field <= (field == FLD_ODD) ? FLD_EVEN : FLD_ODD;
      else                        field <= late_half ? FLD_ODD : FLD_EVEN;
    end
  end
endmodule

// File: rtl/field_frame_gen.sv
module field_frame_gen
  import field_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int GUARD       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [LEN_W-1:0] line_len,
  input  logic             video_on,
  input  logic             dis_frame,
  input  logic             auto_frame,
  input  logic             field_pol,
  output logic             frame_out,
  output logic             field_odd
);
  logic             hs_rise, vs_rise;
  logic [LEN_W-1:0] hpos;
  field_e           field_raw;
  logic             frame_gate;

  sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst(rst), .async_in(hsync_in), .rise(hs_rise));

  sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst(rst), .async_in(vsync_in), .rise(vs_rise));

  hpos_counter #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(hs_rise), .pos(hpos));

  parity_classifier #(.W(LEN_W), .GUARD(GUARD)) u_cls (
    .clk(clk), .rst(rst), .sample(vs_rise), .pos(hpos),
    .line_len(line_len), .field(field_raw));

  assign frame_gate = dis_frame | (auto_frame & video_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_out <= 1'b0;
      field_odd <= 1'b0;
    end else begin
      frame_out <= ~frame_gate & (field_raw == FLD_ODD);
      field_odd <= (field_raw == FLD_ODD) ^ field_pol;
    end
  end
endmodule

// File: rtl/field_frame_chk.sv
module field_frame_chk (
  input logic clk,
  input logic rst,
  input logic vs_rise,
  input logic field_raw,
  input logic video_on,
  input logic dis_frame,
  input logic auto_frame,
  input logic frame_out,
  input logic field_odd
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!frame_out && !field_odd)); // R9
  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst) dis_frame |=> !frame_out); // R4
  AST_AUTO_VIDEO_LOW: assert property (@(posedge clk) disable iff (rst)
    (auto_frame && video_on) |=> !frame_out); // R5
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(field_raw)); // R8
  AST_FRAME_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!dis_frame && !auto_frame) |=> (frame_out == $past(field_raw))); // R2
endmodule

bind field_frame_gen field_frame_chk u_chk (
  .clk(clk), .rst(rst), .vs_rise(vs_rise), .field_raw(field_raw),
  .video_on(video_on), .dis_frame(dis_frame), .auto_frame(auto_frame),
  .frame_out(frame_out), .field_odd(field_odd));

// File: tb/tb_field_frame_gen.sv
module tb_field_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hsync_in = 1'b0, vsync_in = 1'b0;
  logic [LEN_W-1:0] line_len = 12'd100;
  logic             video_on = 1'b0, dis_frame = 1'b0, auto_frame = 1'b0, field_pol = 1'b0;
  logic             frame_out, field_odd;

  int n_chk = 0, n_bad = 0;
  int phase = 0, vs_off = 0, vs_cnt = 0;
  bit vs_arm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_frame_gen dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .line_len(line_len), .video_on(video_on), .dis_frame(dis_frame),
    .auto_frame(auto_frame), .field_pol(field_pol),
    .frame_out(frame_out), .field_odd(field_odd));

  always @(negedge clk) begin
    if (phase >= int'(line_len) - 1) phase = 0;
    else phase = phase + 1;
    hsync_in = (phase < 8);
    if (vs_arm && phase == vs_off) begin
      vs_arm = 1'b0;
      vs_cnt = 20;
    end
    vsync_in = (vs_cnt != 0);
    if (vs_cnt != 0) vs_cnt = vs_cnt - 1;
  end

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic fire(input int off);
    @(negedge clk);
    vs_off = off;
    vs_arm = 1'b1;
    wait (!vs_arm);
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset();
    check(frame_out, 1'b0, "R9 frame after reset");
    check(field_odd, 1'b0, "R9 field after reset");
  endtask

  task automatic t_halves();
    fire(20);
    check(field_odd, 1'b0, "R1 early edge field");
    check(frame_out, 1'b0, "R1 early edge frame");
    fire(70);
    check(field_odd, 1'b1, "R2 late edge field");
    check(frame_out, 1'b1, "R2 late edge frame");
    repeat (250) @(negedge clk);
    check(field_odd, 1'b1, "R8 field held over lines");
    check(frame_out, 1'b1, "R8 frame held over lines");
  endtask

  task automatic t_guard();
    fire(50);
    check(field_odd, 1'b0, "R3 mid guard toggles odd->even");
    fire(50);
    check(field_odd, 1'b1, "R3 mid guard toggles even->odd");
    fire(1);
    check(field_odd, 1'b0, "R3 start guard toggles");
    fire(99);
    check(field_odd, 1'b1, "R3 end-of-line guard toggles");
    check(frame_out, 1'b1, "R3 frame follows toggled field");
  endtask

  task automatic t_gating();
    @(negedge clk) dis_frame = 1'b1;
    repeat (3) @(negedge clk);
    check(frame_out, 1'b0, "R4 disable forces frame low");
    check(field_odd, 1'b1, "R4 field unaffected by disable");
    dis_frame = 1'b0; auto_frame = 1'b1; video_on = 1'b0;
    repeat (3) @(negedge clk);
    check(frame_out, 1'b1, "R5 auto text-only frame follows");
    video_on = 1'b1;
    repeat (3) @(negedge clk);
    check(frame_out, 1'b0, "R5 auto with video frame low");
    auto_frame = 1'b0; video_on = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_polarity();
    @(negedge clk) field_pol = 1'b1;
    repeat (3) @(negedge clk);
    check(field_odd, 1'b0, "R6 polarity inverts field flag");
    check(frame_out, 1'b1, "R6 polarity leaves frame");
    fire(20);
    check(field_odd, 1'b1, "R6 even field inverted flag");
    check(frame_out, 1'b0, "R6 even field frame");
    @(negedge clk) field_pol = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_length();
    @(negedge clk) line_len = 12'd60;
    repeat (200) @(negedge clk);
    fire(40);
    check(field_odd, 1'b1, "R7 short line edge at 40 odd");
    fire(20);
    check(field_odd, 1'b0, "R7 short line edge at 20 even");
    fire(40);
    check(frame_out, 1'b1, "R7 short line frame odd");
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    repeat (200) @(negedge clk);
    t_halves();
    t_guard();
    t_gating();
    t_polarity();
    t_length();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule